// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives the sampling and bit-timing strobes for a serial receiver and transmitter from a fast system clock. It works as a numerically controlled oscillator. Every clock cycle a 16-bit phase increment is added into a 16-bit phase accumulator. Each carry out of that add becomes a one-cycle oversample strobe. The mean strobe rate is therefore `inc / 2^16` of the clock, and it can be a fraction rather than an integer division of it.

A second stage counts oversample strobes and emits one bit-time strobe for every sixteen of them. The transmitter shifts on that strobe, and idle timeout counters count it. The resulting bit rate is `f_clk * inc / 2^20`. Software is expected to compute the increment and round it down, so the rate comes out at or just below the one requested. When the increment is above 40, the rounding error stays under 2.5 %.

Top module: `baud_nco_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the phase accumulator and divider count are cleared, and both strobes are low after that edge.
- R2: After n consecutive enabled clock edges counted from a cleared state, with a constant increment `inc`, `tick_os` has been high in exactly floor(n*inc/65536) of the sampled cycles.
- R3: `tick_os` is a one-cycle pulse per carry. With a constant increment below 32768, it is never high in two consecutive cycles.
- R4: An increment of zero produces no `tick_os` and no `tick_bit`.
- R5: While `en` is low at a clock edge, the accumulator and divider are cleared and both strobes are low after that edge. Counting restarts from zero phase when `en` returns high.
- R6: `tick_bit` goes high one cycle after every sixteenth `tick_os` strobe. After n enabled edges, the number of `tick_bit` strobes equals floor(T/16), where T is the `tick_os` count after n-1 edges.
- R7: The divider count never reaches the division ratio, so `tick_bit` is never high in a cycle that did not follow a `tick_os` strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears all phase state |
| nco_inc | input | 16 | Phase increment added each cycle |
| tick_os | output | 1 | Oversample strobe, one cycle per accumulator carry |
| tick_bit | output | 1 | Bit-time strobe, one per sixteen oversample strobes |

## Verification
The hardest case to reach from the ports is the exact phase alignment that a fractional increment builds up over thousands of cycles. A single lost or doubled carry shifts the strobe count by one only after a long run. The bench sweeps a set of increments that covers zero, one, values around half scale, and full scale. For each, it compares the running strobe counts against floor arithmetic on every cycle. Enable and reset are dropped in the middle of back-to-back carries at full-scale increment, which shows the phase restarting from zero.

// File: rtl/baud_nco_pkg.sv
package baud_nco_pkg;
  localparam int unsigned NCO_W_DEF = 16;
  localparam int unsigned OVS_DEF   = 16;
endpackage

// File: rtl/nco_accum.sv
module nco_accum #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         en_i,
  input  logic [W-1:0] inc_i,
  output logic         tick_o
);
  localparam logic [W-1:0] HALF = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] phase_q;
  logic         carry_q;
  logic [W:0]   sum;

  always_comb sum = {1'b0, phase_q} + {1'b0, inc_i};

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      phase_q <= '0;
      carry_q <= 1'b0;
    end else begin
      phase_q <= sum[W-1:0];
      carry_q <= sum[W];
    end
  end

  assign tick_o = carry_q;

  // R3: with a steady increment below half scale, a carry cannot repeat at once
  assert_single_pulse_R3: assert property (@(posedge clk_i) disable iff (rst_i || !en_i)
    (carry_q && inc_i < HALF && inc_i == $past(inc_i)) |=> !carry_q);

  // R4: a carry needs a nonzero increment on the edge that produced it
  assert_zero_inc_silent_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    carry_q |-> $past(inc_i) != '0);

  // R5: a low enable leaves no phase and no strobe behind
  assert_disable_clears_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(en_i) |-> (!carry_q && phase_q == '0));

  // R1: reset clears the phase
  assert_reset_clears_R1: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!carry_q && phase_q == '0));
endmodule

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned RATIO = 16
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic en_i,
  input  logic tick_i,
  output logic tick_o
);
  generate
    if (RATIO <= 1) begin : g_pass
      logic q;
      always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) q <= 1'b0;
        else                q <= tick_i;
      end
      assign tick_o = q;
    end else begin : g_count
      localparam int unsigned CW = $clog2(RATIO);
      localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

      logic [CW-1:0] cnt_q;
      logic          out_q;

      always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
          cnt_q <= '0;
          out_q <= 1'b0;
        end else if (tick_i) begin
          if (cnt_q == LAST) begin
            cnt_q <= '0;
            out_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            out_q <= 1'b0;
          end
        end else begin
          out_q <= 1'b0;
        end
      end

      assign tick_o = out_q;

      // R7: the count stays inside the ratio
      assert_cnt_in_range_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        cnt_q <= LAST);
    end
  endgenerate

  // R6: a bit strobe only ever follows an oversample strobe
  assert_bit_follows_os_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    tick_o |-> $past(tick_i));
endmodule

// File: rtl/baud_nco_gen.sv
module baud_nco_gen #(
  parameter int unsigned NCO_W = baud_nco_pkg::NCO_W_DEF,
  parameter int unsigned OVS   = baud_nco_pkg::OVS_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [NCO_W-1:0] nco_inc,
  output logic             tick_os,
  output logic             tick_bit
);
  logic os_strobe;

  nco_accum #(.W(NCO_W)) u_accum (
    .clk_i  (clk),
    .rst_i  (rst),
    .en_i   (en),
    .inc_i  (nco_inc),
    .tick_o (os_strobe)
  );

  tick_divider #(.RATIO(OVS)) u_div (
    .clk_i  (clk),
    .rst_i  (rst),
    .en_i   (en),
    .tick_i (os_strobe),
    .tick_o (tick_bit)
  );

  assign tick_os = os_strobe;

  // R5: the bit strobe is also silenced by a low enable
  assert_bit_disable_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !tick_bit);
endmodule

// File: tb/baud_nco_gen_bench.sv
`timescale 1ns/1ps
module baud_nco_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en  = 1'b0;
  logic [15:0] nco_inc = '0;
  logic        tick_os;
  logic        tick_bit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  baud_nco_gen u_baud_nco_gen (
    .clk(clk), .rst(rst), .en(en), .nco_inc(nco_inc),
    .tick_os(tick_os), .tick_bit(tick_bit)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // run n enabled edges from a cleared state and compare counts each cycle
  task automatic sweep(input logic [15:0] inc, input int n);
    longint os_cnt, bit_cnt, exp_os, exp_bit, prev_exp_os;
    bit prev;
    en = 1'b0; nco_inc = inc;
    step();
    en = 1'b1;
    os_cnt = 0; bit_cnt = 0; prev = 1'b0; prev_exp_os = 0;
    for (int i = 1; i <= n; i++) begin
      step();
      os_cnt  += tick_os;
      bit_cnt += tick_bit;
      exp_os  = (longint'(i) * inc) / 65536;
      exp_bit = prev_exp_os / 16;
      check(os_cnt == exp_os, "R2", os_cnt, exp_os);
      check(bit_cnt == exp_bit, "R6", bit_cnt, exp_bit);
      if (inc == 0) check(!tick_os && !tick_bit, "R4", tick_os, 0);
      if (inc < 16'h8000) check(!(prev && tick_os), "R3", tick_os, 0);
      prev = tick_os;
      prev_exp_os = exp_os;
    end
  endtask

  initial begin
    logic [15:0] incs [10] = '{16'd0, 16'd1, 16'd41, 16'd1000, 16'd4096,
                               16'd12345, 16'd32767, 16'd32768, 16'd40000, 16'hFFFF};
    step(); step();
    check(!tick_os && !tick_bit, "R1", {tick_os, tick_bit}, 0);
    rst = 1'b0;
    for (int k = 0; k < 10; k++) sweep(incs[k], 4096);

    // R5: drop enable while strobes are nearly continuous
    sweep(16'hFFFF, 64);
    check(tick_os == 1'b1, "R2", tick_os, 1);
    en = 1'b0;
    step();
    check(!tick_os && !tick_bit, "R5", {tick_os, tick_bit}, 0);
    step();
    check(!tick_os && !tick_bit, "R5", {tick_os, tick_bit}, 0);
    // restart from zero phase: first enabled edge with 0xFFFF gives no carry
    en = 1'b1;
    step();
    check(!tick_os, "R5", tick_os, 0);
    step();
    check(tick_os, "R5", tick_os, 1);

    // R1: reset in mid run
    for (int i = 0; i < 40; i++) step();
    rst = 1'b1;
    step();
    check(!tick_os && !tick_bit, "R1", {tick_os, tick_bit}, 0);
    rst = 1'b0;
    step();
    check(!tick_os, "R1", tick_os, 0);

    // R7: bit strobe only ever follows an oversample strobe
    sweep(16'd30000, 3000);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  logic os_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst && tick_bit && !os_prev && !done) begin
      fails++;
      $display("FAIL R7 actual=%0d expected=%0d at %0t", tick_bit, 0, $time);
    end
    os_prev <= tick_os;
  end

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule